// File: doc/BRIEF.md
# Dual-Word Programmable Clock Divider

This block divides its clock by a programmable ratio using a down counter that reloads itself each time it reaches zero. Two divide words live in two holding registers, each written through its own load strobe. A select input picks, at every reload, which of the two stored words the counter starts from next. This lets the divider alternate between two moduli, for example in a dual-modulus prescaler loop, without rewriting a single preset.

A one-clock terminal-count pulse marks every completed division cycle. A synchronous reset clears both holding registers and the counter. A count enable freezes the counter without losing its position. The divide words are configuration values rather than a data stream, so every pin is a plain level or strobe with no handshake.

Top module: `dualmod_divider`

## Requirements
- R1: While `rst` is high at a rising edge, both holding registers become zero, the counter returns to its unprimed state and `tc_pulse` is low after that edge.
- R2: At a rising edge with `load_a` high, word A takes the value of `word_a`; `load_b` and `word_b` do the same for word B. The two registers are written independently, and a load is accepted whether or not `cnt_en` is high.
- R3: At each reload, `sel_b` as sampled on that same rising edge chooses the source: 0 takes word A, 1 takes word B.
- R4: With `cnt_en` held high, a stored word P from 1 to 255 gives one `tc_pulse` every P+1 clocks. A stored word of 0 gives one every 256 clocks.
- R5: `tc_pulse` is high for exactly one clock, in the cycle right after the edge at which the reload happens.
- R6: At a rising edge with `cnt_en` low, the counter keeps its value, no reload happens and `tc_pulse` is low after that edge. Each disabled edge lengthens the current division cycle by one clock.
- R7: A reload uses the holding register contents as they were before the reload edge. A load strobed on the reload edge itself takes effect only at the following reload.
- R8: After reset is released, the first enabled edge loads the selected word without a pulse. For a word with ratio N, the first `tc_pulse` then follows N enabled edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock to be divided |
| rst | input | 1 | Synchronous active-high master reset |
| cnt_en | input | 1 | Count enable; low freezes the counter |
| word_a | input | 8 | Divide word written into holding register A |
| load_a | input | 1 | Write strobe for register A |
| word_b | input | 8 | Divide word written into holding register B |
| load_b | input | 1 | Write strobe for register B |
| sel_b | input | 1 | Reload source: 0 = register A, 1 = register B |
| tc_pulse | output | 1 | Registered one-clock terminal-count pulse |

## Verification
The assertions assume the bench holds `rst` high through the first clock edge, so every `$past` value they use comes from a reset or a later cycle. They also assume that no division cycle is shorter than two clocks, which holds because the smallest ratio is 2. The bench changes inputs only on falling edges, so each input has one defined value at every rising edge. The single race of interest, a load on the reload edge, is placed on purpose by counting edges from the previous pulse. Ratios are checked across every possible A word and across a spread of B words, and each word is settled for one cycle before its period is measured.

// File: rtl/dmd_pkg.sv
package dmd_pkg;

  // Number of holding registers the reload selector chooses between.
  localparam int unsigned NUM_WORDS = 2;

  // Counter sequencing: unprimed after reset, running after the first load.
  typedef enum logic [0:0] {
    CNT_IDLE = 1'b0,
    CNT_RUN  = 1'b1
  } cnt_state_e;

endpackage

// File: rtl/dmd_word_bank.sv
module dmd_word_bank #(
  parameter int unsigned WORD_W = 8,
  parameter int unsigned N_WORD = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [N_WORD-1:0][WORD_W-1:0]  words_i,
  input  logic [N_WORD-1:0]              load_i,
  output logic [N_WORD-1:0][WORD_W-1:0]  words_q
);

  // One independent holding register per word, written on its own strobe.
  for (genvar g = 0; g < N_WORD; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        words_q[g] <= '0;
      end else if (load_i[g]) begin
        words_q[g] <= words_i[g];
      end
    end
  end

endmodule

// File: rtl/dmd_reload_sel.sv
module dmd_reload_sel #(
  parameter int unsigned WORD_W = 8,
  parameter int unsigned N_WORD = 2,
  localparam int unsigned SEL_W = (N_WORD > 1) ? $clog2(N_WORD) : 1
) (
  input  logic [N_WORD-1:0][WORD_W-1:0] words_q,
  input  logic [SEL_W-1:0]              sel_i,
  output logic [WORD_W-1:0]             reload_o
);

  logic [WORD_W-1:0] picked;

  always_comb begin
    picked = words_q[0];
    for (int i = 0; i < N_WORD; i++) begin
      if (sel_i == SEL_W'(i)) picked = words_q[i];
    end
  end

  // A zero word means the full counter range: reload all ones so the
  // cycle spans 2**WORD_W clocks.
  assign reload_o = (picked == '0) ? {WORD_W{1'b1}} : picked;

endmodule

// File: rtl/dmd_down_counter.sv
module dmd_down_counter
  import dmd_pkg::*;
#(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [WORD_W-1:0] reload_i,
  output logic [WORD_W-1:0] count_q,
  output logic              tc_q
);

  cnt_state_e state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= CNT_IDLE;
      count_q <= '0;
      tc_q    <= 1'b0;
    end else if (en) begin
      unique case (state_q)
        CNT_IDLE: begin
          count_q <= reload_i;
          state_q <= CNT_RUN;
          tc_q    <= 1'b0;
        end
        CNT_RUN: begin
          if (count_q == '0) begin
            count_q <= reload_i;
            tc_q    <= 1'b1;
          end else begin
            count_q <= count_q - 1'b1;
            tc_q    <= 1'b0;
          end
        end
        default: begin
          state_q <= CNT_IDLE;
          tc_q    <= 1'b0;
        end
      endcase
    end else begin
      tc_q <= 1'b0;
    end
  end

endmodule

// File: rtl/dualmod_divider.sv
module dualmod_divider
  import dmd_pkg::*;
#(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_en,
  input  logic [WORD_W-1:0] word_a,
  input  logic              load_a,
  input  logic [WORD_W-1:0] word_b,
  input  logic              load_b,
  input  logic              sel_b,
  output logic              tc_pulse
);

  localparam int unsigned SEL_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  logic [NUM_WORDS-1:0][WORD_W-1:0] words_in;
  logic [NUM_WORDS-1:0][WORD_W-1:0] words_q;
  logic [NUM_WORDS-1:0]             loads;
  logic [WORD_W-1:0]                reload_val;
  logic [WORD_W-1:0]                count_q;
  logic [WORD_W-1:0]                reg_a_q;
  logic [WORD_W-1:0]                reg_b_q;
  logic [SEL_W-1:0]                 sel_idx;

  assign words_in[0] = word_a;
  assign words_in[1] = word_b;
  assign loads       = {load_b, load_a};
  assign sel_idx     = SEL_W'(sel_b);
  assign reg_a_q     = words_q[0];
  assign reg_b_q     = words_q[1];

  dmd_word_bank #(.WORD_W(WORD_W), .N_WORD(NUM_WORDS)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .words_i (words_in),
    .load_i  (loads),
    .words_q (words_q)
  );

  dmd_reload_sel #(.WORD_W(WORD_W), .N_WORD(NUM_WORDS)) u_sel (
    .words_q  (words_q),
    .sel_i    (sel_idx),
    .reload_o (reload_val)
  );

  dmd_down_counter #(.WORD_W(WORD_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .en       (cnt_en),
    .reload_i (reload_val),
    .count_q  (count_q),
    .tc_q     (tc_pulse)
  );

endmodule

// File: rtl/dualmod_divider_chk.sv
module dualmod_divider_chk #(
  parameter int unsigned WORD_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cnt_en,
  input logic [WORD_W-1:0] word_a,
  input logic              load_a,
  input logic [WORD_W-1:0] word_b,
  input logic              load_b,
  input logic              sel_b,
  input logic              tc_pulse,
  input logic [WORD_W-1:0] reg_a_q,
  input logic [WORD_W-1:0] reg_b_q,
  input logic [WORD_W-1:0] count_q
);

  // R1: the first edge after reset release never yields a pulse
  p_quiet_release_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !tc_pulse);

  // R2: each holding register captures its own word on its own strobe
  p_load_a_r2: assert property (@(posedge clk) disable iff (rst)
    load_a |=> reg_a_q == $past(word_a));

  p_load_b_r2: assert property (@(posedge clk) disable iff (rst)
    load_b |=> reg_b_q == $past(word_b));

  // R3, R7: reload value comes from the selected register's old contents
  p_reload_src_r3: assert property (@(posedge clk) disable iff (rst)
    tc_pulse |-> count_q == (($past(sel_b) ? $past(reg_b_q) : $past(reg_a_q)) == '0
                              ? {WORD_W{1'b1}}
                              : ($past(sel_b) ? $past(reg_b_q) : $past(reg_a_q))));

  // R5: the pulse lasts exactly one clock
  p_tc_narrow_r5: assert property (@(posedge clk) disable iff (rst)
    tc_pulse |=> !tc_pulse);

  // R6: a disabled edge freezes the counter and emits nothing
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> $stable(count_q) && !tc_pulse);

endmodule

bind dualmod_divider dualmod_divider_chk #(.WORD_W(WORD_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cnt_en   (cnt_en),
  .word_a   (word_a),
  .load_a   (load_a),
  .word_b   (word_b),
  .load_b   (load_b),
  .sel_b    (sel_b),
  .tc_pulse (tc_pulse),
  .reg_a_q  (reg_a_q),
  .reg_b_q  (reg_b_q),
  .count_q  (count_q)
);

// File: tb/tb_dualmod_divider.sv
module tb_dualmod_divider;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst;
  logic       cnt_en;
  logic [7:0] word_a;
  logic       load_a;
  logic [7:0] word_b;
  logic       load_b;
  logic       sel_b;
  logic       tc_pulse;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dualmod_divider dut (
    .clk      (clk),
    .rst      (rst),
    .cnt_en   (cnt_en),
    .word_a   (word_a),
    .load_a   (load_a),
    .word_b   (word_b),
    .load_b   (load_b),
    .sel_b    (sel_b),
    .tc_pulse (tc_pulse)
  );

  function automatic int ratio_of(input int p);
    return (p == 0) ? 256 : p + 1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Steps until tc_pulse is seen; returns the number of edges taken.
  task automatic wait_tc(output int n);
    n = 0;
    do begin
      step();
      n++;
    end while (!tc_pulse && n < 600);
  endtask

  task automatic load_word(input bit to_b, input logic [7:0] v);
    if (to_b) begin word_b = v; load_b = 1'b1; end
    else      begin word_a = v; load_a = 1'b1; end
    step();
    load_a = 1'b0;
    load_b = 1'b0;
  endtask

  // Lets the new word settle in, then measures one full period.
  task automatic settle_and_measure(output int n);
    int dummy;
    wait_tc(dummy);
    wait_tc(n);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles >= WATCHDOG && !done) begin
      done = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    int m;
    bit quiet;
    rst = 1'b1; cnt_en = 1'b0; word_a = '0; word_b = '0;
    load_a = 1'b0; load_b = 1'b0; sel_b = 1'b0;
    repeat (3) step();
    check(tc_pulse == 1'b0, "R1 reset pulse", int'(tc_pulse), 0);

    // R8, R2: load while disabled, then count from release
    rst = 1'b0;
    step();
    load_word(1'b0, 8'd5);
    check(tc_pulse == 1'b0, "R2 load while disabled", int'(tc_pulse), 0);
    cnt_en = 1'b1;
    wait_tc(n);
    check(n == 7, "R8 first pulse after release", n, 7);

    // R5 width, R4 period
    step();
    check(tc_pulse == 1'b0, "R5 pulse width", int'(tc_pulse), 0);
    wait_tc(m);
    check(m + 1 == 6, "R4 ratio for 5", m + 1, 6);

    // R6: 20 disabled edges stretch the cycle
    step(); step();
    cnt_en = 1'b0;
    quiet = 1'b1;
    for (int i = 0; i < 20; i++) begin
      step();
      if (tc_pulse) quiet = 1'b0;
    end
    check(quiet, "R6 no pulse while disabled", int'(quiet), 1);
    cnt_en = 1'b1;
    wait_tc(n);
    check(n + 22 == 26, "R6 stretched cycle", n + 22, 26);

    // R1: reset clears both words, so the ratio becomes 256
    rst = 1'b1;
    step();
    check(tc_pulse == 1'b0, "R1 pulse cleared", int'(tc_pulse), 0);
    rst = 1'b0;
    wait_tc(n);
    check(n == 257, "R1 cleared word gives 256", n, 257);

    // R3: select between two stored words
    load_word(1'b1, 8'd3);
    load_word(1'b0, 8'd7);
    sel_b = 1'b1;
    settle_and_measure(n);
    check(n == 4, "R3 select B", n, 4);
    sel_b = 1'b0;
    settle_and_measure(n);
    check(n == 8, "R3 select A", n, 8);

    // R7: load on the reload edge applies one cycle later
    load_word(1'b0, 8'd9);
    settle_and_measure(n);
    check(n == 10, "R4 ratio for 9", n, 10);
    repeat (9) step();
    word_a = 8'd4; load_a = 1'b1;
    step();
    load_a = 1'b0;
    check(tc_pulse == 1'b1, "R7 reload on load edge", int'(tc_pulse), 1);
    wait_tc(n);
    check(n == 10, "R7 old word used", n, 10);
    wait_tc(n);
    check(n == 5, "R7 new word next cycle", n, 5);

    // R4: every word through register A
    for (int p = 0; p < 256; p++) begin
      load_word(1'b0, 8'(p));
      settle_and_measure(n);
      check(n == ratio_of(p), "R4 sweep A", n, ratio_of(p));
    end

    // R3: spread of words through register B, A left at a different ratio
    load_word(1'b0, 8'd2);
    sel_b = 1'b1;
    for (int p = 1; p < 256; p += 23) begin
      load_word(1'b1, 8'(p));
      settle_and_measure(n);
      check(n == ratio_of(p), "R3 sweep B", n, ratio_of(p));
    end

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule